// File: doc/BRIEF.md
# System Clock Gating Register Set

This block holds the enable bits for a small group of system clocks: the USB device port clock, the USB host port clock and four programmable clock outputs. Software changes them through a simple register bus. It writes ones to a set register to turn enables on and ones to a clear register to turn them off. A third, read-only register reports every enable as it stands. The outputs are clock-enable levels meant for integrated clock gating cells placed elsewhere.

The USB device port also drives a suspend indication into the block. While suspend is asserted, hardware forces the device clock enable off, and software cannot turn it back on until suspend ends. A separate option bit, handled through the same set and clear registers, controls the master clock to the device port. When this bit is set, that master clock is also gated for the duration of suspend. It comes back automatically when suspend ends, as long as the option is still set.

Top module: `sys_clk_gate`

## Requirements
- R1: After reset every enable bit is 0, the status register reads 0x0000_0000, devClkEn, hostClkEn and pckEn are 0, and devMckEn is 1.
- R2: A bus write to offset 0x0 sets each enable whose bit is 1 in the write data, effective at the clock edge that takes the write. Bits written 0 leave their enable unchanged.
- R3: A bus write to offset 0x4 clears each enable whose bit is 1 in the write data, effective at the clock edge that takes the write. Bits written 0 leave their enable unchanged.
- R4: A read of offset 0x8 returns the enables in the same cycle, with this bit map: bit 1 device clock, bit 2 master-on-suspend option, bit 4 host clock, bits 8 to 11 programmable outputs 0 to 3. All other bits read 0, and reads of offsets 0x0 and 0x4 return 0.
- R5: devClkEn equals status bit 1, hostClkEn equals status bit 4, and pckEn[k] equals status bit 8+k.
- R6: At each clock edge where devSuspend is 1, the device clock enable is cleared. A set of bit 1 taken at that same edge loses to the clear.
- R7: With the option bit set, devMckEn is 0 after each edge where devSuspend is 1. With the option bit clear, devMckEn stays 1 through suspend.
- R8: At the first edge with devSuspend 0, devMckEn returns to 1. The device clock enable stays 0 until software sets it again.
- R9: Write data in unmapped bit positions, writes to the status offset and the suspend input have no effect on the host clock, option or programmable-output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| devSuspend | input | 1 | Suspend indication from the USB device port |
| devClkEn | output | 1 | Enable for the USB device port 48 MHz clock gate |
| hostClkEn | output | 1 | Enable for the USB host port clock gate |
| devMckEn | output | 1 | Enable for the master clock gate of the device port |
| pckEn | output | 4 | Enables for programmable clock outputs 0 to 3 |

## Verification
Each enable is a single flop that drives an output pin directly. A flop holding the wrong value therefore shows on its enable output, and in the next status read, one cycle after the write or suspend edge that caused it. A wrong priority between the suspend clear and a software set shows as devClkEn high after the edge where suspend was present. A fault in the master-clock gate shows as devMckEn staying high into suspend, or staying low one edge past suspend's end. For these reasons the bench checks outputs and status right after every stimulus edge, including directed runs of held suspend.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_SET  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

  localparam int DEV_BIT  = 1;
  localparam int OPT_BIT  = 2;
  localparam int HOST_BIT = 4;
  localparam int NUM_PCK  = 4;
  localparam int PCK_LSB  = 8;

  function automatic logic [DATA_W-1:0] implMask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[DEV_BIT]  = 1'b1;
    m[OPT_BIT]  = 1'b1;
    m[HOST_BIT] = 1'b1;
    for (int k = 0; k < NUM_PCK; k++) m[PCK_LSB + k] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL_MASK = implMask();

  typedef struct packed {
    logic setWr;
    logic clrWr;
    logic statRd;
  } ctlStrobes_t;

endpackage

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       strobes
);

  logic isSet;
  logic isClr;
  logic isStat;

  always_comb begin
    isSet  = (busAddr == OFS_SET);
    isClr  = (busAddr == OFS_CLR);
    isStat = (busAddr == OFS_STAT);
    strobes.setWr  = busSel & busWrite & isSet;
    strobes.clrWr  = busSel & busWrite & isClr;
    strobes.statRd = busSel & ~busWrite & isStat;
  end

endmodule

// File: rtl/clkgate_dp.sv
module clkgate_dp
  import clkgate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              devSuspend,
  output logic [DATA_W-1:0] stateVec,
  output logic [DATA_W-1:0] rdData,
  output logic              devMckEn
);

  logic unusedBits;
  assign unusedBits = ^(wrData & ~IMPL_MASK);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic bitQ;
      logic setHit;
      logic clrHit;
      assign setHit = strobes.setWr & wrData[b];
      if (b == DEV_BIT) begin : g_dev
        // hardware suspend clear joins the software clear and wins over set
        assign clrHit = (strobes.clrWr & wrData[b]) | devSuspend;
      end else begin : g_plain
        assign clrHit = strobes.clrWr & wrData[b];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       bitQ <= 1'b0;
        else if (clrHit) bitQ <= 1'b0;
        else if (setHit) bitQ <= 1'b1;
      end
      assign stateVec[b] = bitQ;
    end else begin : g_rsvd
      assign stateVec[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) devMckEn <= 1'b1;
    else       devMckEn <= ~(devSuspend & stateVec[OPT_BIT]);
  end

  assign rdData = strobes.statRd ? stateVec : '0;

endmodule

// File: rtl/sys_clk_gate.sv
module sys_clk_gate
  import clkgate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              devSuspend,
  output logic              devClkEn,
  output logic              hostClkEn,
  output logic              devMckEn,
  output logic [NUM_PCK-1:0] pckEn
);

  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] stateVec;

  clkgate_ctrl u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  clkgate_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (busWdata),
    .devSuspend (devSuspend),
    .stateVec   (stateVec),
    .rdData     (busRdata),
    .devMckEn   (devMckEn)
  );

  assign devClkEn  = stateVec[DEV_BIT];
  assign hostClkEn = stateVec[HOST_BIT];
  assign pckEn     = stateVec[PCK_LSB +: NUM_PCK];

endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk
  import clkgate_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              devSuspend,
  input logic              devClkEn,
  input logic              hostClkEn,
  input logic              devMckEn,
  input logic [NUM_PCK-1:0] pckEn,
  input logic [DATA_W-1:0] stateVec
);

  // R2
  host_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFS_SET && busWdata[HOST_BIT]) |=> hostClkEn);

  // R3
  host_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFS_CLR && busWdata[HOST_BIT]) |=> !hostClkEn);

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |-> ((busRdata & ~IMPL_MASK) == '0));

  // R6
  suspend_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    devSuspend |=> !devClkEn);

  // R7
  mck_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devSuspend && stateVec[OPT_BIT]) |=> !devMckEn);

  // R8
  mck_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devSuspend |=> devMckEn);

  // R9
  pck_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite && (busAddr == OFS_SET || busAddr == OFS_CLR)) |=> $stable(pckEn));

endmodule

bind sys_clk_gate clkgate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .devSuspend (devSuspend),
  .devClkEn   (devClkEn),
  .hostClkEn  (hostClkEn),
  .devMckEn   (devMckEn),
  .pckEn      (pckEn),
  .stateVec   (stateVec)
);

// File: tb/tb_sys_clk_gate.sv
module tb_sys_clk_gate;

  localparam int OP_IDLE = 0;
  localparam int OP_SET  = 1;
  localparam int OP_CLR  = 2;
  localparam int OP_STW  = 3;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] data;
    logic        susp;
    logic [31:0] expStat;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 32'h0000_0012, 1'b0, 32'h0000_0012},  // R2 set dev+host
    '{2'd1, 32'h0000_0F00, 1'b0, 32'h0000_0F12},  // R2 set outputs
    '{2'd2, 32'h0000_0500, 1'b0, 32'h0000_0A12},  // R3 clear 0 and 2
    '{2'd1, 32'h0000_0000, 1'b0, 32'h0000_0A12},  // R2 zero write
    '{2'd2, 32'h0000_0000, 1'b0, 32'h0000_0A12},  // R3 zero write
    '{2'd1, 32'hFFFF_F0E9, 1'b0, 32'h0000_0A12},  // R9 unmapped bits
    '{2'd3, 32'hFFFF_FFFF, 1'b0, 32'h0000_0A12},  // R9 status write
    '{2'd0, 32'h0000_0000, 1'b1, 32'h0000_0A10},  // R6 suspend clears
    '{2'd1, 32'h0000_0002, 1'b1, 32'h0000_0A10},  // R6 clear beats set
    '{2'd1, 32'h0000_0004, 1'b1, 32'h0000_0A14},  // R9 option set in suspend
    '{2'd0, 32'h0000_0000, 1'b0, 32'h0000_0A14},  // R8 dev stays off
    '{2'd1, 32'h0000_0002, 1'b0, 32'h0000_0A16},  // R2 dev back on
    '{2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},  // R3 clear all
    '{2'd1, 32'h0000_0F16, 1'b0, 32'h0000_0F16}   // R2 set all
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        devSuspend = 1'b0;
  logic        devClkEn;
  logic        hostClkEn;
  logic        devMckEn;
  logic [3:0]  pckEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sys_clk_gate dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .devSuspend(devSuspend), .devClkEn(devClkEn), .hostClkEn(hostClkEn),
    .devMckEn(devMckEn), .pckEn(pckEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation at the falling edge; it takes effect at the next rising edge
  task automatic doOp(input int op, input logic [31:0] data, input logic susp);
    @(negedge clk);
    devSuspend = susp;
    busSel   = (op != OP_IDLE);
    busWrite = 1'b1;
    busWdata = data;
    busAddr  = (op == OP_SET) ? 4'h0 : (op == OP_CLR) ? 4'h4 : 4'h8;
  endtask

  task automatic readReg(input logic [3:0] addr, output logic [31:0] val);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = addr; busWdata = '0;
    #1 val = busRdata;
  endtask

  task automatic idleCycle(input logic susp);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; devSuspend = susp;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    readReg(4'h8, rd);
    check("R1 status", rd, 32'h0);
    check("R1 outputs", {26'd0, devClkEn, hostClkEn, pckEn}, 32'h0);
    check("R1 devMckEn", {31'd0, devMckEn}, 32'h1);
    @(negedge clk);
    rstN = 1'b1;
    busSel = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      doOp(int'(VECS[i].op), VECS[i].data, VECS[i].susp);
      readReg(4'h8, rd);
      check($sformatf("R4 vec %0d status", i), rd, VECS[i].expStat);
      check($sformatf("R5 vec %0d outputs", i),
            {26'd0, devClkEn, hostClkEn, pckEn},
            {26'd0, VECS[i].expStat[1], VECS[i].expStat[4], VECS[i].expStat[11:8]});
    end

    // R4 other offsets read zero
    readReg(4'h0, rd);
    check("R4 read set offset", rd, 32'h0);
    readReg(4'h4, rd);
    check("R4 read clear offset", rd, 32'h0);

    // R7 option set (status 0xF16): suspend gates master clock
    idleCycle(1'b1);
    @(negedge clk);
    check("R7 devMckEn gated", {31'd0, devMckEn}, 32'h0);
    check("R6 dev cleared", {31'd0, devClkEn}, 32'h0);
    repeat (3) @(negedge clk);
    check("R7 gated while held", {31'd0, devMckEn}, 32'h0);
    check("R9 host and outputs held", {27'd0, hostClkEn, pckEn}, 32'h1F);
    idleCycle(1'b0);
    @(negedge clk);
    check("R8 devMckEn restored", {31'd0, devMckEn}, 32'h1);
    check("R8 dev stays off", {31'd0, devClkEn}, 32'h0);

    // R7 option clear: master clock not gated
    doOp(OP_CLR, 32'h0000_0004, 1'b0);
    idleCycle(1'b1);
    @(negedge clk);
    check("R7 no gating without option", {31'd0, devMckEn}, 32'h1);
    idleCycle(1'b0);
    readReg(4'h8, rd);
    check("R4 final status", rd, 32'h0000_0F10);
    @(negedge clk);
    busSel = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule